// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This block adds or subtracts two signed operands stored in sign-magnitude form and returns a sign-magnitude result. It is purely combinational. The top bit of each word carries the sign and the remaining bits carry an unsigned magnitude. The sign bits never enter the adder. A small decoder combines the two operand signs with the requested operation and decides whether the magnitudes are summed or differenced. A magnitude comparator orders the operands so that a difference is always the larger magnitude minus the smaller. The comparator's verdict also supplies the result sign.

The operand width is a parameter. A W-bit word covers the range ±(2^(W-1) − 1), and zero has a positive and a negative encoding. On the input side both encodings of zero are accepted. On the output side a zero magnitude is always returned as +0. When a sum of magnitudes does not fit in W-1 bits, a flag reports the overflow and the result holds the truncated sum.

Top module: `sm_addsub`

## Requirements
- R1: Each port word is {sign, magnitude}. Bit W-1 is the sign (0 non-negative, 1 negative) and bits W-2..0 are the magnitude. When the effective signs agree, the result magnitude is the sum of the operand magnitudes and the result sign is the common sign.
- R2: When the effective signs differ, the result magnitude is the larger operand magnitude minus the smaller one, and the result takes the sign of the operand with the larger magnitude.
- R3: `ovf_o` is 1 exactly when the magnitudes are summed and the sum carries out of bit W-2. In that case the result magnitude is the sum truncated to W-1 bits. A difference of magnitudes never raises `ovf_o`.
- R4: `sub_i` = 0 selects A + B and `sub_i` = 1 selects A − B. Subtraction behaves as addition with the sign of B inverted.
- R5: A result whose magnitude is zero always has sign bit 0. This holds even when the rules would give a negative sign, and even when `ovf_o` is 1.
- R6: When the effective signs differ and the two magnitudes are equal, the result is +0 (all bits zero) and `ovf_o` is 0.
- R7: An operand of −0 (sign 1, magnitude 0) acts as zero. Adding it to or subtracting it from X gives X, or +0 when X is a zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | Operand A, sign-magnitude |
| opb_i | input | W | Operand B, sign-magnitude |
| sub_i | input | 1 | 0 = A + B, 1 = A − B |
| res_o | output | W | Result, sign-magnitude, never −0 |
| ovf_o | output | 1 | Magnitude sum overflowed W-1 bits |

## Verification
The bench targets the cases where sign selection is easy to get wrong.

- **Differing signs with the larger magnitude in the second operand.** A design that takes A's sign unconditionally returns the wrong sign here. One that skips the operand swap returns a wrapped difference.
- **Equal magnitudes with opposite effective signs, and sums of two negative zeros.** A design without zero normalisation emits −0 for these.
- **Overflow at the top of the range.** The checks include 127 + 1, whose truncated magnitude is zero, and large-magnitude differences. A flag driven from the raw carry would fire falsely on the differences, since a difference always produces a carry.

A sweep then compares every combination of boundary magnitudes, signs and operations against an integer model.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;

  typedef enum logic {
    SM_OP_ADD = 1'b0,
    SM_OP_SUB = 1'b1
  } sm_op_e;

  typedef struct packed {
    logic sign_a;
    logic sign_b_eff;
    logic mag_sub;
  } sm_plan_t;

endpackage

// File: rtl/sm_op_decode.sv
module sm_op_decode
  import sm_addsub_pkg::*;
(
  input  logic     sign_a_i,
  input  logic     sign_b_i,
  input  sm_op_e   op_i,
  output sm_plan_t plan_o
);

  logic sign_b_eff;

  always_comb begin
    sign_b_eff        = (op_i == SM_OP_SUB) ? ~sign_b_i : sign_b_i;
    plan_o.sign_a     = sign_a_i;
    plan_o.sign_b_eff = sign_b_eff;
    plan_o.mag_sub    = sign_a_i ^ sign_b_eff;
  end

endmodule

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] a_i,
  input  logic [MW-1:0] b_i,
  output logic          a_gt_o,
  output logic          a_eq_o
);

  logic [MW-1:0] bit_gt;
  logic [MW-1:0] bit_eq;

  for (genvar i = 0; i < MW; i++) begin : g_bit
    assign bit_gt[i] = a_i[i] & ~b_i[i];
    assign bit_eq[i] = ~(a_i[i] ^ b_i[i]);
  end

  always_comb begin
    logic gt_acc;
    logic eq_acc;
    gt_acc = 1'b0;
    eq_acc = 1'b1;
    for (int i = MW - 1; i >= 0; i--) begin
      gt_acc = gt_acc | (eq_acc & bit_gt[i]);
      eq_acc = eq_acc & bit_eq[i];
    end
    a_gt_o = gt_acc;
    a_eq_o = eq_acc;
  end

endmodule

// File: rtl/sm_mag_addsub.sv
module sm_mag_addsub #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] x_i,
  input  logic [MW-1:0] y_i,
  input  logic          sub_i,
  output logic [MW-1:0] sum_o,
  output logic          cout_o
);

  logic [MW-1:0] y_eff;
  logic [MW-1:0] prop;
  logic [MW-1:0] gen;

  assign y_eff = sub_i ? ~y_i : y_i;

  for (genvar i = 0; i < MW; i++) begin : g_pg
    assign prop[i] = x_i[i] ^ y_eff[i];
    assign gen[i]  = x_i[i] & y_eff[i];
  end

  always_comb begin
    logic carry;
    carry = sub_i;
    for (int i = 0; i < MW; i++) begin
      sum_o[i] = prop[i] ^ carry;
      carry    = gen[i] | (prop[i] & carry);
    end
    cout_o = carry;
  end

endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import sm_addsub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);

  localparam int MW = W - 1;

  sm_plan_t      plan;
  sm_op_e        op;
  logic [MW-1:0] mag_a;
  logic [MW-1:0] mag_b;
  logic          a_gt;
  logic          a_eq;
  logic          a_ge;
  logic [MW-1:0] big_mag;
  logic [MW-1:0] small_mag;
  logic [MW-1:0] raw_mag;
  logic          raw_cout;
  logic          raw_sign;
  logic          mag_zero;

  assign op    = sm_op_e'(sub_i);
  assign mag_a = opa_i[MW-1:0];
  assign mag_b = opb_i[MW-1:0];

  sm_op_decode u_dec (
    .sign_a_i (opa_i[W-1]),
    .sign_b_i (opb_i[W-1]),
    .op_i     (op),
    .plan_o   (plan)
  );

  sm_mag_cmp #(.MW(MW)) u_cmp (
    .a_i    (mag_a),
    .b_i    (mag_b),
    .a_gt_o (a_gt),
    .a_eq_o (a_eq)
  );

  assign a_ge      = a_gt | a_eq;
  assign big_mag   = a_ge ? mag_a : mag_b;
  assign small_mag = a_ge ? mag_b : mag_a;

  sm_mag_addsub #(.MW(MW)) u_add (
    .x_i    (big_mag),
    .y_i    (small_mag),
    .sub_i  (plan.mag_sub),
    .sum_o  (raw_mag),
    .cout_o (raw_cout)
  );

  always_comb begin
    if (plan.mag_sub) raw_sign = a_ge ? plan.sign_a : plan.sign_b_eff;
    else              raw_sign = plan.sign_a;
    mag_zero = (raw_mag == '0);
    res_o    = {raw_sign & ~mag_zero, raw_mag};
    ovf_o    = ~plan.mag_sub & raw_cout;
  end

  always_comb begin
    // R2: a difference of ordered magnitudes never borrows
    p_sub_no_borrow_r2: assert (!plan.mag_sub || raw_cout)
      else $error("difference of magnitudes borrowed");
    // R3: the flag appears only on a magnitude sum
    p_ovf_on_sum_r3: assert (!ovf_o || !plan.mag_sub)
      else $error("overflow raised on a difference");
    // R5: negative zero never leaves the block
    p_no_neg_zero_r5: assert (!(res_o[W-1] && res_o[MW-1:0] == '0))
      else $error("negative zero produced");
    // R6: cancelling equal magnitudes gives +0
    p_cancel_pos_zero_r6: assert (!(plan.mag_sub && a_eq) || (res_o == '0 && !ovf_o))
      else $error("equal magnitudes did not cancel to +0");
    // R1: a non-zero sum carries the common sign
    p_sum_sign_r1: assert (plan.mag_sub || mag_zero || res_o[W-1] == plan.sign_a)
      else $error("sum sign differs from operand sign");
  end

endmodule

// File: tb/sm_addsub_bench.sv
module sm_addsub_bench;

  localparam int W  = 8;
  localparam int MW = W - 1;
  localparam int NV = 21;

  logic         clk = 1'b0;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         sub;
  logic [W-1:0] res;
  logic         ovf;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sm_addsub #(.W(W)) u_sm_addsub (
    .opa_i (opa),
    .opb_i (opb),
    .sub_i (sub),
    .res_o (res),
    .ovf_o (ovf)
  );

  // {sub, a, b, expected result, expected overflow}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h05, 8'h03, 8'h08, 1'b0},  // R1 5+3
    {1'b0, 8'h85, 8'h83, 8'h88, 1'b0},  // R1 -5+-3
    {1'b0, 8'h05, 8'h89, 8'h84, 1'b0},  // R2 5+-9
    {1'b0, 8'h85, 8'h09, 8'h04, 1'b0},  // R2 -5+9
    {1'b0, 8'h64, 8'h32, 8'h16, 1'b1},  // R3 100+50
    {1'b0, 8'hE4, 8'hB2, 8'h96, 1'b1},  // R3 -100+-50
    {1'b0, 8'h7F, 8'hFF, 8'h00, 1'b0},  // R6 127+-127
    {1'b0, 8'hBC, 8'h3C, 8'h00, 1'b0},  // R6 -60+60
    {1'b1, 8'h05, 8'h03, 8'h02, 1'b0},  // R4 5-3
    {1'b1, 8'h03, 8'h05, 8'h82, 1'b0},  // R4 3-5
    {1'b1, 8'h05, 8'h83, 8'h08, 1'b0},  // R4 5-(-3)
    {1'b1, 8'hE4, 8'h32, 8'h96, 1'b1},  // R3 -100-50
    {1'b0, 8'h80, 8'h80, 8'h00, 1'b0},  // R5 -0+-0
    {1'b1, 8'h80, 8'h00, 8'h00, 1'b0},  // R5 -0-0
    {1'b0, 8'h80, 8'h07, 8'h07, 1'b0},  // R7 -0+7
    {1'b1, 8'h00, 8'h07, 8'h87, 1'b0},  // R4 0-7
    {1'b1, 8'h14, 8'h14, 8'h00, 1'b0},  // R6 20-20
    {1'b0, 8'h7F, 8'h01, 8'h00, 1'b1},  // R5 127+1 wraps to +0
    {1'b0, 8'h7F, 8'h00, 8'h7F, 1'b0},  // R3 127+0 fits
    {1'b1, 8'h7F, 8'hFF, 8'h7E, 1'b1},  // R3 127-(-127)
    {1'b0, 8'h7F, 8'h81, 8'h7E, 1'b0}   // R3 no flag on difference
  };

  localparam int VREQ [NV] = '{1,1,2,2,3,3,6,6,4,4,4,3,5,5,7,4,6,5,3,3,3};

  task automatic apply(input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    #1;
    sub = s;
    opa = a;
    opb = b;
    @(negedge clk);
  endtask

  task automatic check(input int req, input logic [W-1:0] er, input logic eo);
    n_run++;
    if (res !== er || ovf !== eo) begin
      n_fail++;
      $display("FAIL R%0d: a=%h b=%h sub=%b got res=%h ovf=%b expected res=%h ovf=%b",
               req, opa, opb, sub, res, ovf, er, eo);
    end
  endtask

  function automatic int to_int(input logic [W-1:0] v);
    int m;
    m = int'(v[MW-1:0]);
    return v[W-1] ? -m : m;
  endfunction

  initial begin
    logic [W-1:0] mags [6];
    mags = '{7'd0, 7'd1, 7'd63, 7'd64, 7'd126, 7'd127};
    opa = '0;
    opb = '0;
    sub = 1'b0;
    // R1 initial: +0 + +0
    apply(1'b0, 8'h00, 8'h00);
    check(1, 8'h00, 1'b0);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][25], VEC[i][24:17], VEC[i][16:9]);
      check(VREQ[i], VEC[i][8:1], VEC[i][0]);
    end
    // R2 R3 R4 R5 sweep against an integer model
    for (int ia = 0; ia < 12; ia++) begin
      for (int ib = 0; ib < 12; ib++) begin
        for (int s = 0; s < 2; s++) begin
          logic [W-1:0] a;
          logic [W-1:0] b;
          int r;
          int mr;
          logic eo;
          logic [W-1:0] er;
          a = {ia[0], mags[ia/2][MW-1:0]};
          b = {ib[0], mags[ib/2][MW-1:0]};
          r = s[0] ? to_int(a) - to_int(b) : to_int(a) + to_int(b);
          mr = (r < 0) ? -r : r;
          eo = (mr > (1 << MW) - 1);
          mr = mr % (1 << MW);
          er = {(r < 0) && (mr != 0), mr[MW-1:0]};
          apply(s[0], a, b);
          check(s[0] ? 4 : 2, er, eo);
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule